// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides what the chip does after the processor reports that it has executed a stop instruction. It reads a handful of control bits and picks one outcome. The outcome is wait mode, one of three stop depths, an illegal-opcode reset or an illegal-instruction exception. While a low-power mode is active, it drives the clock-gate enables for the CPU, bus and peripheral domains. It also drives the I/O latch-hold signal.

The block also handles the way out of each mode. An enabled interrupt ends wait, stop3 and stop4. The deepest level, stop2, ends only on the active-low wake pin or an enabled real-time-counter wake. Leaving stop2 triggers a power-on-style reset, with a retain qualifier for the register groups that must survive it. A debug enable bit, captured at entry, turns stop4 into peripheral-only gating. With that bit captured, a debug background command in stop4 leads to halt. Debug memory accesses are refused with an error status while the block is in any low-power state.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: A `stop_req` in run mode with `cfg_wait_en`=1 enters wait (`mode`=1) whatever `cfg_stop_en` is. In wait, only `cpu_clk_en` is 0; `bus_clk_en` and `per_clk_en` stay 1.
- R2: A `stop_req` in run mode with `cfg_stop_en`=1 and `cfg_wait_en`=0 enters the level given by `cfg_level`, sampled on that cycle. The encodings are 00 -> stop4 (`mode`=2), 01 -> stop3 (`mode`=3), 10 -> stop2 (`mode`=4) and 11 -> stop3.
- R3: A `stop_req` in run mode with both enables 0 leaves `mode` at run (0). One cycle later it gives a one-cycle `illegal_rst` if `cfg_rst_dis`=0, or a one-cycle `illegal_exc` if `cfg_rst_dis`=1.
- R4: In stop3, all three clock enables are 0.
- R5: If `cfg_dbg_en` was 1 on the cycle stop4 was accepted, only `per_clk_en` is 0 in stop4. Otherwise all three enables are 0. Changing `cfg_dbg_en` after entry has no effect.
- R6: `io_hold` is 1 on every cycle spent in stop2 and 0 in every other mode, and all three clock enables are 0 in stop2.
- R7: Stop2 is left only when `wake_pin_n` is 0, or when `rtc_wake` and `rtc_wake_en` are both 1. An `irq`, or `rtc_wake` without `rtc_wake_en`, leaves the mode unchanged.
- R8: On leaving stop2, `mode` returns to run on the next cycle. On that same cycle, `por_rst` and `retain` each pulse for exactly one cycle.
- R9: In stop4 with the debug enable captured, `dbg_bkgd` returns `mode` to run on the next cycle with one-cycle `halt_req` and `wake_done` pulses. This holds even when `irq` is high on the same cycle. Without the captured enable, `dbg_bkgd` is ignored.
- R10: `dbg_mem_req` gives `dbg_mem_go`=1, `dbg_mem_err`=0 in run mode, and `dbg_mem_go`=0, `dbg_mem_err`=1 in any other mode, in the same cycle.
- R11: `irq` in wait, stop3 or stop4 returns `mode` to run on the next cycle with all clock enables 1 and a one-cycle `wake_done`.
- R12: `stop_req` outside run mode is ignored. After reset, `mode` is 0, all clock enables are 1 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_req | input | 1 | Stop instruction executed |
| cfg_stop_en | input | 1 | Stop modes allowed |
| cfg_wait_en | input | 1 | Wait mode selected |
| cfg_rst_dis | input | 1 | Fault is an exception instead of a reset |
| cfg_dbg_en | input | 1 | Debug enable, captured at entry |
| cfg_level | input | 2 | Stop depth select |
| irq | input | 1 | Enabled interrupt pending |
| wake_pin_n | input | 1 | Active-low wake pin |
| rtc_wake | input | 1 | Real-time-counter wake request |
| rtc_wake_en | input | 1 | Real-time-counter wake enable |
| dbg_bkgd | input | 1 | Debug background command |
| dbg_mem_req | input | 1 | Debug memory access request |
| mode | output | 3 | 0 run, 1 wait, 2 stop4, 3 stop3, 4 stop2 |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| io_hold | output | 1 | I/O control latch hold |
| illegal_rst | output | 1 | Illegal-opcode reset pulse |
| illegal_exc | output | 1 | Illegal-instruction exception pulse |
| por_rst | output | 1 | Power-on-style reset pulse after stop2 |
| retain | output | 1 | Spare retained register groups from `por_rst` |
| halt_req | output | 1 | Enter debug halt pulse |
| wake_done | output | 1 | Wake from wait/stop3/stop4 pulse |
| dbg_mem_go | output | 1 | Debug access may proceed |
| dbg_mem_err | output | 1 | Debug access refused, low-power state |

## Verification
In stop4 with the debug enable captured, an interrupt and a background command can both arrive in the same cycle. The bench raises `irq` and `dbg_bkgd` together on one cycle. It expects one return to run, with `halt_req` and `wake_done` both pulsing and the clocks back on. In stop2 the same pairing is judged the other way round. There, `irq` arrives together with an unenabled real-time-counter wake, and the mode must hold with `io_hold` still set.

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       cfg_stop_en,
  input  logic       cfg_wait_en,
  input  logic       cfg_rst_dis,
  input  logic       cfg_dbg_en,
  input  logic [1:0] cfg_level,
  input  logic       irq,
  input  logic       wake_pin_n,
  input  logic       rtc_wake,
  input  logic       rtc_wake_en,
  input  logic       dbg_bkgd,
  input  logic       dbg_mem_req,
  output logic [2:0] mode,
  output logic       cpu_clk_en,
  output logic       bus_clk_en,
  output logic       per_clk_en,
  output logic       io_hold,
  output logic       illegal_rst,
  output logic       illegal_exc,
  output logic       por_rst,
  output logic       retain,
  output logic       halt_req,
  output logic       wake_done,
  output logic       dbg_mem_go,
  output logic       dbg_mem_err
);

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_WAIT  = 3'd1,
    M_STOP4 = 3'd2,
    M_STOP3 = 3'd3,
    M_STOP2 = 3'd4
  } mode_e;

  mode_e mode_q;
  logic  dbg_lat;
  logic  stop2_wake;

  assign stop2_wake = !wake_pin_n || (rtc_wake && rtc_wake_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_RUN;
      dbg_lat     <= 1'b0;
      illegal_rst <= 1'b0;
      illegal_exc <= 1'b0;
      por_rst     <= 1'b0;
      retain      <= 1'b0;
      halt_req    <= 1'b0;
      wake_done   <= 1'b0;
    end else begin
      illegal_rst <= 1'b0;
      illegal_exc <= 1'b0;
      por_rst     <= 1'b0;
      retain      <= 1'b0;
      halt_req    <= 1'b0;
      wake_done   <= 1'b0;
      case (mode_q)
        M_RUN: begin
          if (stop_req) begin
            if (cfg_wait_en) begin
              mode_q <= M_WAIT;
            end else if (cfg_stop_en) begin
              dbg_lat <= cfg_dbg_en;
              case (cfg_level)
                2'b00:   mode_q <= M_STOP4;
                2'b10:   mode_q <= M_STOP2;
                default: mode_q <= M_STOP3;
              endcase
            end else if (cfg_rst_dis) begin
              illegal_exc <= 1'b1;
            end else begin
              illegal_rst <= 1'b1;
            end
          end
        end
        M_WAIT, M_STOP3: begin
          if (irq) begin
            mode_q    <= M_RUN;
            wake_done <= 1'b1;
          end
        end
        M_STOP4: begin
          if (dbg_bkgd && dbg_lat) begin
            mode_q    <= M_RUN;
            halt_req  <= 1'b1;
            wake_done <= 1'b1;
          end else if (irq) begin
            mode_q    <= M_RUN;
            wake_done <= 1'b1;
          end
        end
        M_STOP2: begin
          if (stop2_wake) begin
            mode_q  <= M_RUN;
            por_rst <= 1'b1;
            retain  <= 1'b1;
          end
        end
        default: mode_q <= M_RUN;
      endcase
    end
  end

  assign mode        = mode_q;
  assign cpu_clk_en  = (mode_q == M_RUN) || (mode_q == M_STOP4 && dbg_lat);
  assign bus_clk_en  = (mode_q == M_RUN) || (mode_q == M_WAIT) ||
                       (mode_q == M_STOP4 && dbg_lat);
  assign per_clk_en  = (mode_q == M_RUN) || (mode_q == M_WAIT);
  assign io_hold     = (mode_q == M_STOP2);
  assign dbg_mem_go  = dbg_mem_req && (mode_q == M_RUN);
  assign dbg_mem_err = dbg_mem_req && (mode_q != M_RUN);

endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       cfg_stop_en,
  input logic       cfg_wait_en,
  input logic [1:0] cfg_level,
  input logic       dbg_bkgd,
  input logic [2:0] mode,
  input logic       cpu_clk_en,
  input logic       io_hold,
  input logic       illegal_rst,
  input logic       illegal_exc,
  input logic       por_rst,
  input logic       halt_req,
  input logic       wake_done
);

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_hold) |-> $past(stop_req && cfg_stop_en && !cfg_wait_en && cfg_level == 2'b10)); // R6

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_rst, illegal_exc, por_rst, halt_req})); // R3

  AST_POR_FROM_STOP2: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst |-> ($past(mode) == 3'd4 && mode == 3'd0)); // R8

  AST_WAKE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (mode == 3'd0 && cpu_clk_en)); // R11

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> ($past(dbg_bkgd) && $past(mode) == 3'd2)); // R9

  AST_LOWPOWER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) |=> (mode == $past(mode) || mode == 3'd0)); // R12

endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk i_chk (.*);

// File: tb/test_lpm_entry_ctrl.sv
`timescale 1ns/100ps
module test_lpm_entry_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, cfg_stop_en = 0, cfg_wait_en = 0, cfg_rst_dis = 0, cfg_dbg_en = 0;
  logic [1:0] cfg_level = 2'b00;
  logic irq = 0, wake_pin_n = 1, rtc_wake = 0, rtc_wake_en = 0, dbg_bkgd = 0, dbg_mem_req = 0;
  logic [2:0] mode;
  logic cpu_clk_en, bus_clk_en, per_clk_en, io_hold, illegal_rst, illegal_exc;
  logic por_rst, retain, halt_req, wake_done, dbg_mem_go, dbg_mem_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lpm_entry_ctrl i_lpm_entry_ctrl (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clocks(string tag, int c, int b, int p);
    check({tag, " cpu_clk_en"}, cpu_clk_en, c);
    check({tag, " bus_clk_en"}, bus_clk_en, b);
    check({tag, " per_clk_en"}, per_clk_en, p);
  endtask

  task automatic issue_stop(logic se, logic we, logic [1:0] lvl);
    cfg_stop_en = se; cfg_wait_en = we; cfg_level = lvl;
    stop_req = 1; step(); stop_req = 0;
  endtask

  task automatic irq_exit(string tag);
    irq = 1; step(); irq = 0;
    check({tag, " mode after irq"}, mode, 0);
    check({tag, " wake_done"}, wake_done, 1);
    clocks(tag, 1, 1, 1);
    step();
    check({tag, " wake_done one cycle"}, wake_done, 0);
  endtask

  task automatic t_reset();
    check("R12 reset mode", mode, 0);
    clocks("R12 reset", 1, 1, 1);
    check("R12 reset pulses", {illegal_rst, illegal_exc, por_rst, retain, halt_req, wake_done, io_hold}, 0);
  endtask

  task automatic t_wait();
    issue_stop(1, 1, 2'b10);
    check("R1 wait mode", mode, 1);
    clocks("R1 wait", 0, 1, 1);
    check("R6 io_hold off in wait", io_hold, 0);
    issue_stop(1, 0, 2'b10);
    check("R12 stop_req in wait ignored", mode, 1);
    irq_exit("R11 wait");
  endtask

  task automatic t_levels();
    issue_stop(1, 0, 2'b01);
    check("R2 level 01", mode, 3);
    clocks("R4 stop3", 0, 0, 0);
    irq_exit("R11 stop3");
    issue_stop(1, 0, 2'b11);
    check("R2 level 11 reserved", mode, 3);
    irq_exit("R11 stop3 reserved");
    cfg_dbg_en = 0;
    issue_stop(1, 0, 2'b00);
    check("R2 level 00", mode, 2);
    cfg_dbg_en = 1;
    step();
    clocks("R5 stop4 no dbg", 0, 0, 0);
    dbg_bkgd = 1; step(); dbg_bkgd = 0;
    check("R9 bkgd ignored mode", mode, 2);
    check("R9 bkgd ignored halt", halt_req, 0);
    irq_exit("R11 stop4");
  endtask

  task automatic t_illegal();
    cfg_rst_dis = 0;
    issue_stop(0, 0, 2'b01);
    check("R3 mode stays run", mode, 0);
    check("R3 illegal_rst", illegal_rst, 1);
    check("R3 no exc", illegal_exc, 0);
    step();
    check("R3 illegal_rst one cycle", illegal_rst, 0);
    cfg_rst_dis = 1;
    issue_stop(0, 0, 2'b10);
    check("R3 exc", illegal_exc, 1);
    check("R3 no rst", illegal_rst, 0);
    check("R3 mode run exc", mode, 0);
    step();
    check("R3 exc one cycle", illegal_exc, 0);
    cfg_rst_dis = 0;
  endtask

  task automatic t_stop4_dbg();
    cfg_dbg_en = 1;
    issue_stop(1, 0, 2'b00);
    cfg_dbg_en = 0;
    step();
    check("R5 stop4 dbg mode", mode, 2);
    clocks("R5 stop4 dbg", 1, 1, 0);
    dbg_bkgd = 1; irq = 1; step(); dbg_bkgd = 0; irq = 0;
    check("R9 bkgd+irq mode", mode, 0);
    check("R9 halt_req", halt_req, 1);
    check("R9 wake_done", wake_done, 1);
    clocks("R9 after halt", 1, 1, 1);
    step();
    check("R9 halt one cycle", halt_req, 0);
  endtask

  task automatic t_stop2(logic use_rtc);
    issue_stop(1, 0, 2'b10);
    check("R2 level 10", mode, 4);
    check("R6 io_hold", io_hold, 1);
    clocks("R6 stop2", 0, 0, 0);
    irq = 1; rtc_wake = 1; rtc_wake_en = 0; step(); irq = 0; rtc_wake = 0;
    check("R7 irq/rtc unenabled ignored", mode, 4);
    check("R6 io_hold held", io_hold, 1);
    dbg_mem_req = 1; #0.5;
    check("R10 err in stop2", dbg_mem_err, 1);
    check("R10 no go in stop2", dbg_mem_go, 0);
    dbg_mem_req = 0;
    if (use_rtc) begin rtc_wake = 1; rtc_wake_en = 1; end
    else wake_pin_n = 0;
    step();
    rtc_wake = 0; rtc_wake_en = 0; wake_pin_n = 1;
    check("R8 mode run", mode, 0);
    check("R8 por_rst", por_rst, 1);
    check("R8 retain", retain, 1);
    check("R6 io_hold released", io_hold, 0);
    check("R11 no wake_done from stop2", wake_done, 0);
    step();
    check("R8 por one cycle", por_rst, 0);
    check("R8 retain one cycle", retain, 0);
  endtask

  task automatic t_mem_run();
    dbg_mem_req = 1; #0.5;
    check("R10 go in run", dbg_mem_go, 1);
    check("R10 no err in run", dbg_mem_err, 0);
    dbg_mem_req = 0;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_wait();
    t_levels();
    t_illegal();
    t_stop4_dbg();
    t_stop2(0);
    t_stop2(1);
    t_mem_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule